// File: doc/BRIEF.md
# Two-Channel Open-Drain Bus Repeater

This block joins two segments of a two-wire open-drain bus, one channel carrying data and one carrying clock, inside FPGA fabric. Each pad is seen as a sampled level plus a pull-down request that is active low. For each channel the repeater finds which segment an outside device is pulling low. It then pulls the other segment low to match and holds it there until the outside device lets go. A low that the repeater itself causes is never taken as a new request. This rules out the state where both pull-downs keep each other asserted.

The repeater does nothing until `en` is high and a connection check has passed: every sampled pad must be high for `CONN_CYCLES` clock cycles in a row. The `ready` output reports this state in open-drain form. On each rising edge of a bus line the block can emit a rise-assist pulse on both sides of the channel. A separate control input can suppress these pulses, and forwarding continues unchanged while it does.

Top module: `od_bus_repeater`

## Requirements
- R1: Each pad input passes through a two-flop synchroniser. If an outside driver pulls one side of a channel low while the repeater is ready and that channel is idle, the pull-down on the other side (`pad_*_pd_n` = 0) asserts after the third rising clock edge. It stays asserted for as long as the driving side is held low.
- R2: While a channel forwards in one direction, the pull-down on its driving side never asserts. This holds when the forwarded side reads low and also when an outside device pulls the forwarded side low as well.
- R3: When the driving side is released high, the opposite pull-down releases after the third rising edge. The channel then ignores the low on the side it was driving until that side is sampled high again.
- R4: If both sides of an idle channel go low in the same sample, side A wins and side B is pulled down.
- R5: The two channels are independent. Index 0 is data and index 1 is clock, and each may forward in a different direction at the same time.
- R6: While `en` is low, every pull-down and every rise-assist output is deasserted in the same cycle. `ready` is 0 after the next rising edge.
- R7: `ready` is 1 only after `en` has been high and all four synchronised pad levels have been high for `CONN_CYCLES` consecutive edges. Before that, no pull-down asserts. Once `ready` is 1 it stays 1 until `en` falls. A value of 0 means the flag is pulled low.
- R8: A rise-assist pulse starts on both sides of a channel on the edge after both synchronised sides become high. This only happens when they were not both high in the previous sample and the repeater is ready. The pulse lasts `PULSE_CYCLES` cycles, and `rise_a[i]` always equals `rise_b[i]`.
- R9: While `accel_en` is low, no rise-assist pulse is output. Forwarding is unaffected.
- R10: While `rst_n` is low, every pull-down is released, every rise output is 0 and `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low means shutdown |
| accel_en | input | 1 | Allows rise-assist pulses |
| pad_a_in | input | NCH | Sampled level, side A of each channel |
| pad_b_in | input | NCH | Sampled level, side B of each channel |
| pad_a_pd_n | output | NCH | Side A pull-down request, active low |
| pad_b_pd_n | output | NCH | Side B pull-down request, active low |
| rise_a | output | NCH | Side A rise-assist pulse |
| rise_b | output | NCH | Side B rise-assist pulse |
| ready | output | 1 | Open-drain-style flag, 1 = released |

## Verification
The bench builds the repeater with `CONN_CYCLES` = 6 and `PULSE_CYCLES` = 3. With these values the first edge of `ready`, and the requalification after `en` toggles, land within a few cycles and can be checked on both sides of the boundary. The full rise-assist pulse, including its last high cycle and the first low cycle after it, fits inside short waits. The bench models each pad as a wired AND of the outside driver and the repeater's own pull-down. This brings the self-induced low of R2 and R3 within reach, along with the masking of that low that follows.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_A2B  = 2'd1,
    DIR_B2A  = 2'd2
  } dir_e;

  // Pick a direction from the synchronised levels; a masked side is ignored.
  // Side A wins when both sides are low in the same sample.
  function automatic dir_e pick_dir(input logic a_lvl, input logic b_lvl,
                                    input logic a_mask, input logic b_mask);
    logic a_req;
    logic b_req;
    a_req = !a_lvl && !a_mask;
    b_req = !b_lvl && !b_mask;
    if (a_req)      return DIR_A2B;
    else if (b_req) return DIR_B2A;
    else            return DIR_IDLE;
  endfunction

  // True when a run counter has reached its limit with the current sample.
  function automatic logic run_done(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  // A new rise event: both levels high now, not both high last sample.
  function automatic logic rise_edge(input logic a_lvl, input logic b_lvl,
                                     input logic both_prev);
    return a_lvl && b_lvl && !both_prev;
  endfunction

endpackage

// File: rtl/rpt_sync.sv
module rpt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rpt_conn_qual.sv
module rpt_conn_qual #(
  parameter int CONN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic all_high,
  output logic connected,
  output logic conn_evt
);
  import rpt_pkg::*;

  localparam int CW = $clog2(CONN_CYCLES + 1);

  logic [CW-1:0] run_cnt;
  logic          conn_q;
  logic          at_limit;

  assign at_limit = run_done(int'(run_cnt), CONN_CYCLES);
  assign conn_evt = en && !conn_q && all_high && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      conn_q  <= 1'b0;
    end else if (!en) begin
      run_cnt <= '0;
      conn_q  <= 1'b0;
    end else if (!conn_q) begin
      if (!all_high) begin
        run_cnt <= '0;
      end else if (at_limit) begin
        conn_q <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign connected = conn_q;

endmodule

// File: rtl/rpt_dir_ctl.sv
module rpt_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic drive_a,
  output logic drive_b
);
  import rpt_pkg::*;

  dir_e dir_q;
  dir_e dir_nx;
  logic mask_a;
  logic mask_b;

  assign dir_nx = pick_dir(a_lvl, b_lvl, mask_a, mask_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_IDLE;
      mask_a <= 1'b0;
      mask_b <= 1'b0;
    end else if (!active) begin
      dir_q  <= DIR_IDLE;
      mask_a <= 1'b0;
      mask_b <= 1'b0;
    end else begin
      // a side we pulled low is unmasked once it reads high and is not driven
      if (a_lvl && dir_q != DIR_B2A) mask_a <= 1'b0;
      if (b_lvl && dir_q != DIR_A2B) mask_b <= 1'b0;
      case (dir_q)
        DIR_IDLE: begin
          dir_q <= dir_nx;
          if (dir_nx == DIR_A2B) mask_b <= 1'b1;
          if (dir_nx == DIR_B2A) mask_a <= 1'b1;
        end
        DIR_A2B: if (a_lvl) dir_q <= DIR_IDLE;
        DIR_B2A: if (b_lvl) dir_q <= DIR_IDLE;
        default: dir_q <= DIR_IDLE;
      endcase
    end
  end

  assign drive_b = (dir_q == DIR_A2B);
  assign drive_a = (dir_q == DIR_B2A);

endmodule

// File: rtl/rpt_rise_gen.sv
module rpt_rise_gen #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic accel,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic fire,
  output logic pulse
);
  import rpt_pkg::*;

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] left_q;
  logic          both_q;

  assign fire = active && accel && rise_edge(a_lvl, b_lvl, both_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_q <= 1'b1;
      left_q <= '0;
    end else begin
      both_q <= a_lvl && b_lvl;
      if (!active || !accel) begin
        left_q <= '0;
      end else if (fire) begin
        left_q <= PLOAD;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/od_bus_repeater.sv
module od_bus_repeater #(
  parameter int NCH          = 2,
  parameter int CONN_CYCLES  = 16,
  parameter int PULSE_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           accel_en,
  input  logic [NCH-1:0] pad_a_in,
  input  logic [NCH-1:0] pad_b_in,
  output logic [NCH-1:0] pad_a_pd_n,
  output logic [NCH-1:0] pad_b_pd_n,
  output logic [NCH-1:0] rise_a,
  output logic [NCH-1:0] rise_b,
  output logic           ready
);

  localparam int SW = 2 * NCH;

  logic [SW-1:0]  sync_q;
  logic [NCH-1:0] a_lvl;
  logic [NCH-1:0] b_lvl;
  logic           all_high;
  logic           connected;
  logic           conn_evt;
  logic           active;
  logic [NCH-1:0] drive_a;
  logic [NCH-1:0] drive_b;
  logic [NCH-1:0] rise_fire;
  logic [NCH-1:0] pulse;

  rpt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pad_b_in, pad_a_in}),
    .q     (sync_q)
  );

  assign a_lvl    = sync_q[NCH-1:0];
  assign b_lvl    = sync_q[SW-1:NCH];
  assign all_high = &sync_q;

  rpt_conn_qual #(.CONN_CYCLES(CONN_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .all_high  (all_high),
    .connected (connected),
    .conn_evt  (conn_evt)
  );

  assign active = en && connected;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rpt_dir_ctl u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .a_lvl   (a_lvl[c]),
      .b_lvl   (b_lvl[c]),
      .drive_a (drive_a[c]),
      .drive_b (drive_b[c])
    );

    rpt_rise_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .accel  (accel_en),
      .a_lvl  (a_lvl[c]),
      .b_lvl  (b_lvl[c]),
      .fire   (rise_fire[c]),
      .pulse  (pulse[c])
    );

    assign pad_a_pd_n[c] = !(drive_a[c] && en);
    assign pad_b_pd_n[c] = !(drive_b[c] && en);
    assign rise_a[c]     = pulse[c] && en && accel_en;
    assign rise_b[c]     = pulse[c] && en && accel_en;
  end

  assign ready = connected;

endmodule

// File: rtl/rpt_chk.sv
module rpt_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           accel_en,
  input logic [NCH-1:0] pad_a_pd_n,
  input logic [NCH-1:0] pad_b_pd_n,
  input logic [NCH-1:0] rise_a,
  input logic [NCH-1:0] rise_b,
  input logic           ready,
  input logic [NCH-1:0] rise_fire,
  input logic           conn_evt
);

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pad_a_pd_n) & (~pad_b_pd_n)) == '0);

  a_r6_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> ((&pad_a_pd_n) && (&pad_b_pd_n) && rise_a == '0 && rise_b == '0));

  a_r6_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);

  a_r7_isolated_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ((&pad_a_pd_n) && (&pad_b_pd_n)));

  a_r7_ready_on_qual: assert property (@(posedge clk) disable iff (!rst_n)
    conn_evt |=> ready);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && en) |=> ready);

  a_r8_pulse_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a == rise_b);

  a_r8_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_fire != '0) |=>
      (((rise_a & $past(rise_fire)) == $past(rise_fire)) || !en || !accel_en));

  a_r9_accel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_en |-> (rise_a == '0 && rise_b == '0));

endmodule

bind od_bus_repeater rpt_chk #(.NCH(NCH)) u_rpt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .accel_en   (accel_en),
  .pad_a_pd_n (pad_a_pd_n),
  .pad_b_pd_n (pad_b_pd_n),
  .rise_a     (rise_a),
  .rise_b     (rise_b),
  .ready      (ready),
  .rise_fire  (rise_fire),
  .conn_evt   (conn_evt)
);

// File: tb/test_od_bus_repeater.sv
`timescale 1ns/1ps
module test_od_bus_repeater;

  localparam int NCH = 2;
  localparam int NV  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic accel_en = 1'b0;
  logic [NCH-1:0] ext_a = '1;
  logic [NCH-1:0] ext_b = '1;
  logic [NCH-1:0] pad_a_in, pad_b_in, pad_a_pd_n, pad_b_pd_n, rise_a, rise_b;
  logic ready;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  // wired-AND pads: outside driver and repeater pull-down
  assign pad_a_in = ext_a & pad_a_pd_n;
  assign pad_b_in = ext_b & pad_b_pd_n;

  od_bus_repeater #(.NCH(NCH), .CONN_CYCLES(6), .PULSE_CYCLES(3)) i_od_bus_repeater (
    .clk(clk), .rst_n(rst_n), .en(en), .accel_en(accel_en),
    .pad_a_in(pad_a_in), .pad_b_in(pad_b_in),
    .pad_a_pd_n(pad_a_pd_n), .pad_b_pd_n(pad_b_pd_n),
    .rise_a(rise_a), .rise_b(rise_b), .ready(ready)
  );

  // {req, ext_a, ext_b, en, acc, wait, exp pdA, pdB, riseA, riseB, ready}
  localparam logic [22:0] VEC [NV] = '{
    {4'd7, 2'b11,2'b11,1'b1,1'b1,4'd5,  2'b11,2'b11,2'b00,2'b00,1'b0}, // R7 one short
    {4'd7, 2'b11,2'b11,1'b1,1'b1,4'd1,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R7 qualified
    {4'd1, 2'b10,2'b11,1'b1,1'b1,4'd2,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R1 not yet
    {4'd1, 2'b10,2'b11,1'b1,1'b1,4'd1,  2'b11,2'b10,2'b00,2'b00,1'b1}, // R1 third edge
    {4'd2, 2'b10,2'b11,1'b1,1'b1,4'd10, 2'b11,2'b10,2'b00,2'b00,1'b1}, // R2 own low ignored
    {4'd2, 2'b10,2'b10,1'b1,1'b1,4'd4,  2'b11,2'b10,2'b00,2'b00,1'b1}, // R2 outside low on B
    {4'd3, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R3 release
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b01,2'b01,1'b1}, // R8 pulse on
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd2,  2'b11,2'b11,2'b01,2'b01,1'b1}, // R8 last high
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd1,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R8 ended
    {4'd5, 2'b01,2'b10,1'b1,1'b1,4'd3,  2'b10,2'b01,2'b00,2'b00,1'b1}, // R5 opposite dirs
    {4'd5, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R5 both release
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b11,2'b11,1'b1}, // R8 both channels
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R8 ended
    {4'd9, 2'b10,2'b11,1'b1,1'b0,4'd3,  2'b11,2'b10,2'b00,2'b00,1'b1}, // R9 forwarding kept
    {4'd9, 2'b11,2'b11,1'b1,1'b0,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R9 release
    {4'd9, 2'b11,2'b11,1'b1,1'b0,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R9 no pulse
    {4'd9, 2'b11,2'b11,1'b1,1'b0,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R9 still none
    {4'd4, 2'b10,2'b10,1'b1,1'b1,4'd3,  2'b11,2'b10,2'b00,2'b00,1'b1}, // R4 A wins
    {4'd4, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R4 release
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b01,2'b01,1'b1}, // R8
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R8
    {4'd1, 2'b10,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b10,2'b00,2'b00,1'b1}, // R1 forward again
    {4'd6, 2'b10,2'b11,1'b0,1'b1,4'd1,  2'b11,2'b11,2'b00,2'b00,1'b0}, // R6 shutdown
    {4'd7, 2'b10,2'b11,1'b1,1'b1,4'd10, 2'b11,2'b11,2'b00,2'b00,1'b0}, // R7 no qual while low
    {4'd7, 2'b11,2'b11,1'b1,1'b1,4'd7,  2'b11,2'b11,2'b00,2'b00,1'b0}, // R7 one short
    {4'd7, 2'b11,2'b11,1'b1,1'b1,4'd1,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R7 requalified
    {4'd1, 2'b01,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b01,2'b00,2'b00,1'b1}, // R1 clock channel
    {4'd3, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b00,2'b00,1'b1}, // R3
    {4'd8, 2'b11,2'b11,1'b1,1'b1,4'd3,  2'b11,2'b11,2'b10,2'b10,1'b1}, // R8 clock pulse
    {4'd6, 2'b11,2'b11,1'b0,1'b1,4'd1,  2'b11,2'b11,2'b00,2'b00,1'b0}, // R6 cuts pulse
    {4'd7, 2'b11,2'b11,1'b1,1'b1,4'd6,  2'b11,2'b11,2'b00,2'b00,1'b1}  // R7 after re-enable
  };

  task automatic check(input int req, input logic [8:0] exp);
    logic [8:0] act;
    act = {pad_a_pd_n, pad_b_pd_n, rise_a, rise_b, ready};
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL R%0d: actual %b expected %b (pdA pdB riseA riseB ready)", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(10, 9'b11_11_00_00_0); // R10 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(10, 9'b11_11_00_00_0); // R10 idle out of reset, en low
    for (int i = 0; i < NV; i++) begin
      ext_a    = VEC[i][18:17];
      ext_b    = VEC[i][16:15];
      en       = VEC[i][14];
      accel_en = VEC[i][13];
      repeat (int'(VEC[i][12:9])) @(negedge clk);
      check(int'(VEC[i][22:19]), VEC[i][8:0]);
    end
    // R10: reset mid-transfer releases everything
    ext_a = 2'b10;
    repeat (3) @(negedge clk);
    check(1, 9'b11_10_00_00_1);
    rst_n = 1'b0;
    @(negedge clk);
    check(10, 9'b11_11_00_00_0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule